// File: doc/BRIEF.md
# Interrupt and Reset Vector Sequencer

This block sits beside a small 8-bit CPU core. It decides when the core stops fetching instructions and runs an exception sequence instead. There are four kinds of sequence: reset, non-maskable interrupt (NMI), maskable interrupt (IRQ) and software break. Each sequence lasts seven bus cycles. Two internal cycles address the stack. Three cycles push the return address high byte, the return address low byte and the status byte. The last two cycles read the vector pair, low byte first and then high byte. The datapath watches `push_sel` to choose the byte it drives for a write. It decrements its stack pointer on `sp_dec` and loads its program counter on `pc_load`.

The interrupt pins are active low. The NMI pin is edge-triggered and is captured into a pending latch. The IRQ pin is level-sensitive and is gated by the interrupt mask flag. The core pulses `insn_boundary` when an instruction ends and pulses `brk_decode` when it decodes a break. A low `rdy` freezes the current cycle. No data stream crosses this block, so every pin is plain control or status and there is no valid/ready handshake.

Top module: `irq_vector_seq`

## Requirements
- R1: While `rst_n` is low, `seq_active` is 0, `vec_pull_n` is 1 and `bus_we` is 0, whatever the value of `rdy`.
- R2: The cycle after `rst_n` is first sampled high, a reset sequence starts and runs for seven cycles. All of its stack cycles are reads. `sp_dec` still pulses three times, and the vector is read from 0xFFFC and then 0xFFFD.
- R3: In steps 2, 3 and 4 of a sequence, `bus_addr` is 0x0100 plus `sp` and `sp_dec` is high. `push_sel` is 1 (PC high), then 2 (PC low), then 3 (status). Outside those steps `push_sel` is 0. For every kind other than reset, these three cycles are writes (`bus_we`=1).
- R4: Steps 5 and 6 read the vector low byte and then the high byte: 0xFFFA/0xFFFB for NMI, and 0xFFFE/0xFFFF for IRQ and break. `vec_pull_n` is low only in these two steps. `set_imask` pulses in step 5 and `pc_load` pulses in step 6.
- R5: IRQ is taken only when `insn_boundary` is high, `irq_n` is low and `i_flag` is 0. The sequence starts on the next cycle.
- R6: A `brk_decode` pulse starts a break sequence on the next cycle, provided no NMI is pending.
- R7: A falling edge of `nmi_n` is latched, even while a sequence is running. The latch clears when the NMI vector read begins. Holding `nmi_n` low raises no second NMI.
- R8: When several requests are present at the start of a sequence, the order of priority is NMI, then IRQ, then break.
- R9: While `rdy` is low during a sequence, the step and all outputs hold. `sp_dec`, `set_imask` and `pc_load` stay low.
- R10: `insn_boundary` and `brk_decode` are ignored while a sequence is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin; its release starts the reset sequence |
| rdy | input | 1 | Ready; low stalls the current cycle |
| nmi_n | input | 1 | Active-low NMI pin, edge-triggered |
| irq_n | input | 1 | Active-low IRQ pin, level-sensitive |
| i_flag | input | 1 | Interrupt mask flag from the status register |
| insn_boundary | input | 1 | Pulse at the last cycle of an instruction |
| brk_decode | input | 1 | Pulse when a break instruction is decoded |
| sp | input | 8 | Current stack pointer from the datapath |
| bus_addr | output | 16 | Bus address during a sequence, 0 when idle |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| push_sel | output | 2 | Byte to push: 0 none, 1 PC high, 2 PC low, 3 status |
| sp_dec | output | 1 | Stack pointer decrement strobe |
| set_imask | output | 1 | Set-I-flag strobe |
| pc_load | output | 1 | Load PC from the two vector bytes |
| vec_pull_n | output | 1 | Low while the vector bytes are read |
| seq_active | output | 1 | A sequence is in progress |

## Verification
If the step counter or the kind register holds a wrong value, the fault appears at the ports in the same cycle. It shows as a stack address off by one, a write during reset, or a vector address from the wrong pair. The cycle-by-cycle scoreboard catches it at that sample. A fault in the NMI latch only shows at the next instruction boundary. It appears either as a missing NMI sequence or as a second sequence while the pin stays low. The bench therefore strobes boundaries both while the pin is held low and after it is released and pulled low again.

// File: rtl/irq_vector_seq_pkg.sv
package irq_vector_seq_pkg;
  localparam int ADDR_W   = 16;
  localparam int SP_W     = 8;
  localparam int SEQ_LEN  = 7;
  localparam int STEP_W   = $clog2(SEQ_LEN);
  localparam int PAGE_W   = ADDR_W - SP_W;
  localparam logic [PAGE_W-1:0] STACK_PAGE = PAGE_W'(1);

  localparam logic [STEP_W-1:0] ST_PCH  = STEP_W'(2);
  localparam logic [STEP_W-1:0] ST_PCL  = STEP_W'(3);
  localparam logic [STEP_W-1:0] ST_STAT = STEP_W'(4);
  localparam logic [STEP_W-1:0] ST_VLO  = STEP_W'(5);
  localparam logic [STEP_W-1:0] ST_VHI  = STEP_W'(6);
  localparam logic [STEP_W-1:0] ST_LAST = STEP_W'(SEQ_LEN - 1);

  typedef enum logic [1:0] {K_RST, K_NMI, K_IRQ, K_BRK} kind_t;

  localparam logic [1:0] PSEL_NONE = 2'd0;
  localparam logic [1:0] PSEL_PCH  = 2'd1;
  localparam logic [1:0] PSEL_PCL  = 2'd2;
  localparam logic [1:0] PSEL_STAT = 2'd3;

  function automatic logic [ADDR_W-1:0] vec_base(kind_t k);
    case (k)
      K_RST:   return ADDR_W'(16'hFFFC);
      K_NMI:   return ADDR_W'(16'hFFFA);
      default: return ADDR_W'(16'hFFFE);
    endcase
  endfunction
endpackage

// File: rtl/irq_vector_seq_nmi.sv
module irq_vector_seq_nmi (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic clr,
  output logic pend
);
  logic nmi_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev <= 1'b1;
      pend     <= 1'b0;
    end else begin
      nmi_prev <= nmi_n;
      if (nmi_prev && !nmi_n) pend <= 1'b1;
      else if (clr)           pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_vector_seq_ctrl.sv
module irq_vector_seq_ctrl
  import irq_vector_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy,
  input  logic              start,
  input  kind_t             start_kind,
  output logic              active,
  output logic [STEP_W-1:0] step,
  output kind_t             kind
);
  logic hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold   <= 1'b1;
      active <= 1'b0;
      step   <= '0;
      kind   <= K_RST;
    end else if (hold) begin
      hold   <= 1'b0;
      active <= 1'b1;
      step   <= '0;
      kind   <= K_RST;
    end else if (active) begin
      if (rdy) begin
        if (step == ST_LAST) active <= 1'b0;
        else                 step   <= step + STEP_W'(1);
      end
    end else if (start) begin
      active <= 1'b1;
      step   <= '0;
      kind   <= start_kind;
    end
  end
endmodule

// File: rtl/irq_vector_seq_bus.sv
module irq_vector_seq_bus
  import irq_vector_seq_pkg::*;
(
  input  logic              active,
  input  logic [STEP_W-1:0] step,
  input  kind_t             kind,
  input  logic              rdy,
  input  logic [SP_W-1:0]   sp,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [1:0]        push_sel,
  output logic              sp_dec,
  output logic              set_imask,
  output logic              pc_load,
  output logic              vec_pull_n
);
  logic push_cyc, vec_cyc;

  always_comb begin
    push_cyc = active && (step == ST_PCH || step == ST_PCL || step == ST_STAT);
    vec_cyc  = active && (step == ST_VLO || step == ST_VHI);

    bus_addr = '0;
    if (vec_cyc)     bus_addr = vec_base(kind) | ADDR_W'(step == ST_VHI);
    else if (active) bus_addr = {STACK_PAGE, sp};

    push_sel = PSEL_NONE;
    if (active) begin
      case (step)
        ST_PCH:  push_sel = PSEL_PCH;
        ST_PCL:  push_sel = PSEL_PCL;
        ST_STAT: push_sel = PSEL_STAT;
        default: push_sel = PSEL_NONE;
      endcase
    end

    bus_we     = push_cyc && (kind != K_RST);
    sp_dec     = push_cyc && rdy;
    set_imask  = active && (step == ST_VLO) && rdy;
    pc_load    = active && (step == ST_VHI) && rdy;
    vec_pull_n = !vec_cyc;
  end
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_vector_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy,
  input  logic              nmi_n,
  input  logic              irq_n,
  input  logic              i_flag,
  input  logic              insn_boundary,
  input  logic              brk_decode,
  input  logic [SP_W-1:0]   sp,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [1:0]        push_sel,
  output logic              sp_dec,
  output logic              set_imask,
  output logic              pc_load,
  output logic              vec_pull_n,
  output logic              seq_active
);
  logic              active, nmi_pend, nmi_clr, irq_ok, start;
  logic [STEP_W-1:0] step;
  kind_t             kind, start_kind;

  irq_vector_seq_nmi u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .clr(nmi_clr), .pend(nmi_pend)
  );

  always_comb begin
    irq_ok  = !irq_n && !i_flag;
    start   = !active && ((insn_boundary && (nmi_pend || irq_ok)) || brk_decode);
    nmi_clr = active && (kind == K_NMI) && (step == ST_VLO);
    if (nmi_pend)    start_kind = K_NMI;
    else if (irq_ok && insn_boundary) start_kind = K_IRQ;
    else             start_kind = K_BRK;
  end

  irq_vector_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .start(start), .start_kind(start_kind),
    .active(active), .step(step), .kind(kind)
  );

  irq_vector_seq_bus u_bus (
    .active(active), .step(step), .kind(kind), .rdy(rdy), .sp(sp),
    .bus_addr(bus_addr), .bus_we(bus_we), .push_sel(push_sel), .sp_dec(sp_dec),
    .set_imask(set_imask), .pc_load(pc_load), .vec_pull_n(vec_pull_n)
  );

  assign seq_active = active;
endmodule

// File: rtl/irq_vector_seq_chk.sv
module irq_vector_seq_chk
  import irq_vector_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rdy,
  input logic              nmi_n,
  input logic              nmi_pend,
  input logic              active,
  input logic [STEP_W-1:0] step,
  input kind_t             kind,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [1:0]        push_sel,
  input logic              sp_dec,
  input logic              pc_load,
  input logic              vec_pull_n
);
  // R4: vector-pull only while reading one of the vector bytes
  p_vec_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_pull_n |-> (bus_addr[15:3] == 13'h1FFF && !bus_we));

  // R4: the PC load happens on the high vector byte
  p_pcload_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (!vec_pull_n && bus_addr[0]));

  // R2: a reset sequence never writes
  p_reset_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && kind == K_RST) |-> !bus_we);

  // R3: each decrement goes with a push select on the stack page
  p_push_stack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sp_dec |-> (push_sel != 2'd0 && bus_addr[15:8] == 8'h01));

  // R9: a stall freezes the step
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rdy) |=> (active && $stable(step)));

  // R7: the pending latch rises only after the pin was low
  p_nmi_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> !$past(nmi_n));
endmodule

bind irq_vector_seq irq_vector_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdy(rdy), .nmi_n(nmi_n), .nmi_pend(nmi_pend),
  .active(active), .step(step), .kind(kind), .bus_addr(bus_addr), .bus_we(bus_we),
  .push_sel(push_sel), .sp_dec(sp_dec), .pc_load(pc_load), .vec_pull_n(vec_pull_n)
);

// File: tb/irq_vector_seq_tb.sv
`timescale 1ns/1ps
module irq_vector_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, rdy = 1'b0, nmi_n = 1'b1, irq_n = 1'b1, i_flag = 1'b1;
  logic insn_boundary = 1'b0, brk_decode = 1'b0;
  logic [7:0] sp = 8'h00;
  logic [15:0] bus_addr;
  logic bus_we, sp_dec, set_imask, pc_load, vec_pull_n, seq_active;
  logic [1:0] push_sel;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .nmi_n(nmi_n), .irq_n(irq_n), .i_flag(i_flag),
    .insn_boundary(insn_boundary), .brk_decode(brk_decode), .sp(sp),
    .bus_addr(bus_addr), .bus_we(bus_we), .push_sel(push_sel), .sp_dec(sp_dec),
    .set_imask(set_imask), .pc_load(pc_load), .vec_pull_n(vec_pull_n), .seq_active(seq_active)
  );

  // datapath stand-in: stack pointer
  always @(posedge clk) if (sp_dec) sp <= sp - 8'd1;

  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic [1:0]  psel;
    logic        spd, seti, pcl, vpn;
    string       tag;
  } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 reset, 1 NMI, 2 IRQ, 3 break
  task automatic exp_seq(input int kind, input logic [7:0] sp0, input string tag);
    logic [15:0] vb;
    vb = (kind == 0) ? 16'hFFFC : (kind == 1) ? 16'hFFFA : 16'hFFFE;
    for (int s = 0; s < 7; s++) begin
      item_t it;
      it.tag  = tag;
      it.addr = (s <= 2) ? {8'h01, sp0} : (s == 3) ? {8'h01, sp0 - 8'd1} :
                (s == 4) ? {8'h01, sp0 - 8'd2} : (s == 5) ? vb : (vb | 16'h0001);
      it.spd  = (s >= 2 && s <= 4);
      it.we   = it.spd && (kind != 0);
      it.psel = it.spd ? 2'(s - 1) : 2'd0;
      it.seti = (s == 5);
      it.pcl  = (s == 6);
      it.vpn  = (s < 5);
      q.push_back(it);
    end
  endtask

  // monitor: compares one scoreboard entry per sequence cycle
  always begin
    @(negedge clk); #2;
    if (rst_n && seq_active) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10 unexpected sequence", {16'h0, bus_addr}, 32'h0);
      end else begin
        item_t e;
        e = q[0];
        chk(bus_addr == e.addr, {e.tag, " R3/R4 addr"}, {16'h0, bus_addr}, {16'h0, e.addr});
        chk(bus_we == e.we, {e.tag, " R2/R3 we"}, {31'h0, bus_we}, {31'h0, e.we});
        chk(push_sel == e.psel, {e.tag, " R3 push_sel"}, {30'h0, push_sel}, {30'h0, e.psel});
        chk(vec_pull_n == e.vpn, {e.tag, " R4 vec_pull_n"}, {31'h0, vec_pull_n}, {31'h0, e.vpn});
        chk(sp_dec == (e.spd && rdy), {e.tag, " R9 sp_dec"}, {31'h0, sp_dec}, {31'h0, e.spd && rdy});
        chk(set_imask == (e.seti && rdy), {e.tag, " R4 set_imask"}, {31'h0, set_imask}, {31'h0, e.seti && rdy});
        chk(pc_load == (e.pcl && rdy), {e.tag, " R4 pc_load"}, {31'h0, pc_load}, {31'h0, e.pcl && rdy});
        if (rdy) void'(q.pop_front());
      end
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() != 0 && guard < 100) begin cyc(); guard++; end
    chk(q.size() == 0, "R9 sequence completed", q.size(), 0);
    cyc();
  endtask

  task automatic idle_check(input string tag);
    cyc(3);
    chk(!seq_active, tag, {31'h0, seq_active}, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    cyc(3);
    // R1: reset hold with rdy low
    chk(!seq_active, "R1 active in reset", {31'h0, seq_active}, 0);
    chk(vec_pull_n, "R1 vec_pull_n in reset", {31'h0, vec_pull_n}, 1);
    chk(!bus_we, "R1 we in reset", {31'h0, bus_we}, 0);

    // R2: reset sequence
    exp_seq(0, 8'h00, "R2 reset");
    rst_n = 1'b1; rdy = 1'b1;
    cyc();
    drain();
    chk(sp == 8'hFD, "R2 sp after reset", {24'h0, sp}, 32'hFD);

    // R5: masked IRQ, then unmasked IRQ without a boundary
    irq_n = 1'b0; i_flag = 1'b1; insn_boundary = 1'b1; cyc(); insn_boundary = 1'b0;
    idle_check("R5 masked irq");
    i_flag = 1'b0;
    idle_check("R5 irq without boundary");

    // R5: IRQ taken; R10 break during it ignored; R7 NMI edge during it
    exp_seq(2, 8'hFD, "R5 irq");
    insn_boundary = 1'b1; cyc(); insn_boundary = 1'b0;
    cyc(); brk_decode = 1'b1; cyc(); brk_decode = 1'b0;
    nmi_n = 1'b0; cyc();
    drain();
    irq_n = 1'b1; i_flag = 1'b1;
    chk(sp == 8'hFA, "R3 sp after irq", {24'h0, sp}, 32'hFA);
    idle_check("R10 no extra sequence");

    // R8: latched NMI beats IRQ and break
    irq_n = 1'b0; i_flag = 1'b0;
    exp_seq(1, 8'hFA, "R8 nmi priority");
    insn_boundary = 1'b1; brk_decode = 1'b1; cyc(); insn_boundary = 1'b0; brk_decode = 1'b0;
    drain();
    irq_n = 1'b1; i_flag = 1'b1;

    // R7: NMI held low does not retrigger
    insn_boundary = 1'b1; cyc(); insn_boundary = 1'b0;
    idle_check("R7 nmi held low");

    // R7: release and fall again -> new NMI
    nmi_n = 1'b1; cyc(2); nmi_n = 1'b0; cyc(2);
    exp_seq(1, 8'hF7, "R7 nmi re-arm");
    insn_boundary = 1'b1; cyc(); insn_boundary = 1'b0;
    drain();

    // R6 with R9 stall in the middle
    exp_seq(3, 8'hF4, "R6 break");
    brk_decode = 1'b1; cyc(); brk_decode = 1'b0;
    cyc(2); rdy = 1'b0; cyc(3); rdy = 1'b1;
    drain();
    chk(sp == 8'hF1, "R9 sp after stalled break", {24'h0, sp}, 32'hF1);

    // R8: IRQ and break together, no NMI -> IRQ vector
    irq_n = 1'b0; i_flag = 1'b0;
    exp_seq(2, 8'hF1, "R8 irq over break");
    insn_boundary = 1'b1; brk_decode = 1'b1; cyc(); insn_boundary = 1'b0; brk_decode = 1'b0;
    drain();

    done = 1'b1;
    summary();
  end
endmodule